// File: doc/BRIEF.md
# Leading and Trailing Bit-Run Counter

This unit sits in the integer execute stage of a 64-bit datapath. It takes one source operand and a 5-bit minor opcode. It returns the length of the run of identical bits at one end of the operand. The run can be of zeros or of ones, and it can be counted from the most significant end (leading) or the least significant end (trailing). The count covers either the low 32-bit word or the full 64-bit doubleword. The count is zero-extended into a 64-bit result.

Every ones count is formed as a zeros count of the inverted operand. Every trailing count is formed as a leading count of the bit-reversed operand. One shared leading-zero counter therefore serves all eight variants. In word mode the low word is moved to the top of the counter's input and the lower half is filled with ones, so the count stops at 32. Results are registered. `valid_out` follows `valid_in` by one clock. An opcode outside the eight assigned values returns zero and raises `illegal_op`.

Top module: `lead_trail_counter`

## Requirements
- R1: Legal opcodes are 4 through 11. Opcode minus 4 gives a 3-bit field: bit 0 selects zeros (1) or ones (0), bit 1 selects trailing (1) or leading (0), and bit 2 selects doubleword (1) or word (0). This gives, in order: 4 leading ones word, 5 leading zeros word, 6 trailing ones word, 7 trailing zeros word, 8 to 11 the same four in doubleword.
- R2: A leading-zeros count returns the number of consecutive 0 bits starting at the most significant bit of the examined width.
- R3: A ones count returns the same value as the matching zeros count applied to the bitwise inverse of the operand.
- R4: A trailing count returns the number of consecutive equal bits starting at bit 0.
- R5: In word mode only operand bits 31:0 are examined; bits 63:32 never change the result.
- R6: A word-mode count whose low word consists entirely of the counted bit value returns 32, whether leading or trailing.
- R7: A doubleword count whose operand consists entirely of the counted bit value returns 64.
- R8: The result is zero-extended; it never exceeds 64, and never exceeds 32 in word mode.
- R9: `valid_out` is high exactly one clock after a cycle with `valid_in` high. The result of that request is present in the same cycle as `valid_out`.
- R10: A request with an illegal opcode produces result 0 and `illegal_op` = 1; a legal request produces `illegal_op` = 0.
- R11: While `rst` is high and after its release, `valid_out`, `illegal_op` and `result` are 0 until the first request.
- R12: While `valid_in` is low, `result` and `illegal_op` keep their last values, whatever the opcode and operand inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| valid_in | input | 1 | Request strobe |
| opcode | input | 5 | Minor opcode selecting the count variant |
| operand | input | 64 | Source operand |
| valid_out | output | 1 | Result strobe, one clock after `valid_in` |
| result | output | 64 | Zero-extended count, 0 to 64 |
| illegal_op | output | 1 | Request carried an unassigned opcode |

## Verification
The assertions assume that `opcode` and `operand` carry known values in every cycle where `valid_in` is high. They check the counter output against the prepared vector only for legal requests. The bench drives every input to a defined level from time zero and changes inputs only on falling edges. Between requests the bench parks `valid_in` low, so that the hold behaviour and the one-cycle strobe can be observed without overlap.

// File: rtl/lzc_pkg.sv
package lzc_pkg;
  localparam int OPC_W    = 5;
  localparam int OPC_BASE = 4;
  localparam int NUM_OPS  = 8;

  // Field order matches (opcode - OPC_BASE): [2] dword, [1] trailing, [0] zeros
  typedef struct packed {
    logic dword;
    logic trailing;
    logic zeros;
  } cnt_op_t;
endpackage

// File: rtl/lzc_decode.sv
module lzc_decode
  import lzc_pkg::*;
#(
  parameter int OW   = OPC_W,
  parameter int BASE = OPC_BASE
) (
  input  logic [OW-1:0] opc,
  output cnt_op_t       op,
  output logic          illegal
);
  logic [OW-1:0] offset;

  // Codes below BASE wrap to large offsets and fall into the illegal range
  assign offset  = opc - OW'(BASE);
  assign illegal = (offset >= OW'(NUM_OPS));
  assign op      = cnt_op_t'(offset[2:0]);
endmodule

// File: rtl/lzc_prep.sv
module lzc_prep
  import lzc_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W-1:0] src,
  input  cnt_op_t      op,
  output logic [W-1:0] vec
);
  localparam int HW = W / 2;

  logic [W-1:0]  polar;
  logic [W-1:0]  rev_full;
  logic [HW-1:0] rev_half;
  logic [W-1:0]  full_sel;
  logic [HW-1:0] half_sel;

  // Ones counts become zeros counts of the inverse
  assign polar = op.zeros ? src : ~src;

  for (genvar i = 0; i < W; i++) begin : g_rev_full
    assign rev_full[i] = polar[W-1-i];
  end
  for (genvar i = 0; i < HW; i++) begin : g_rev_half
    assign rev_half[i] = polar[HW-1-i];
  end

  assign full_sel = op.trailing ? rev_full : polar;
  assign half_sel = op.trailing ? rev_half : polar[HW-1:0];

  // Word mode: low word on top, ones below as a stop so the count saturates at HW
  assign vec = op.dword ? full_sel : {half_sel, {HW{1'b1}}};
endmodule

// File: rtl/lzc_core.sv
module lzc_core #(
  parameter int W   = 64,
  parameter int SEG = 8,
  parameter int CW  = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] cnt
);
  localparam int NSEG = W / SEG;
  localparam int SCW  = $clog2(SEG + 1);

  logic [SCW-1:0]  seg_cnt [NSEG];
  logic [NSEG-1:0] seg_nz;

  // Segment 0 holds the most significant bits
  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    logic [SEG-1:0] bits;
    assign bits      = vec[W-1-s*SEG -: SEG];
    assign seg_nz[s] = |bits;

    always_comb begin
      logic hit;
      hit        = 1'b0;
      seg_cnt[s] = '0;
      for (int j = SEG - 1; j >= 0; j--) begin
        if (!hit) begin
          if (bits[j]) hit = 1'b1;
          else         seg_cnt[s] = seg_cnt[s] + 1'b1;
        end
      end
    end
  end

  always_comb begin
    logic done;
    done = 1'b0;
    cnt  = CW'(W);
    for (int s = 0; s < NSEG; s++) begin
      if (!done && seg_nz[s]) begin
        cnt  = CW'(s * SEG) + CW'(seg_cnt[s]);
        done = 1'b1;
      end
    end
  end
endmodule

// File: rtl/lead_trail_counter.sv
module lead_trail_counter
  import lzc_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int OPC_WD = OPC_W,
  parameter int SEG_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid_in,
  input  logic [OPC_WD-1:0] opcode,
  input  logic [DATA_W-1:0] operand,
  output logic              valid_out,
  output logic [DATA_W-1:0] result,
  output logic              illegal_op
);
  localparam int CW       = $clog2(DATA_W + 1);
  localparam int WORD_MAX = DATA_W / 2;

  cnt_op_t           dec_op;
  logic              dec_illegal;
  logic [DATA_W-1:0] core_vec;
  logic [CW-1:0]     cnt;

  lzc_decode #(.OW(OPC_WD), .BASE(OPC_BASE)) u_decode (
    .opc     (opcode),
    .op      (dec_op),
    .illegal (dec_illegal)
  );

  lzc_prep #(.W(DATA_W)) u_prep (
    .src (operand),
    .op  (dec_op),
    .vec (core_vec)
  );

  lzc_core #(.W(DATA_W), .SEG(SEG_W), .CW(CW)) u_core (
    .vec (core_vec),
    .cnt (cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_out  <= 1'b0;
      result     <= '0;
      illegal_op <= 1'b0;
    end else begin
      valid_out <= valid_in;
      if (valid_in) begin
        result     <= dec_illegal ? '0 : DATA_W'(cnt);
        illegal_op <= dec_illegal;
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    valid_in |=> valid_out); // R9
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
    !valid_in |=> !valid_out); // R9
  AST_RESULT_RANGE: assert property (@(posedge clk) disable iff (rst)
    result <= DATA_W'(DATA_W)); // R8
  AST_WORD_RANGE: assert property (@(posedge clk) disable iff (rst)
    valid_in && !dec_illegal && !dec_op.dword |=> result <= DATA_W'(WORD_MAX)); // R8
  AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (rst)
    illegal_op |-> result == '0); // R10
  AST_COUNT_HITS_ONE: assert property (@(posedge clk) disable iff (rst)
    valid_in && !dec_illegal && (cnt < CW'(DATA_W)) |-> core_vec[DATA_W-1-int'(cnt)]); // R2
  AST_FULL_MEANS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    valid_in && !dec_illegal && (cnt == CW'(DATA_W)) |-> core_vec == '0); // R7
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !valid_in |=> $stable(result) && $stable(illegal_op)); // R12
endmodule

// File: tb/tb_lead_trail_counter.sv
`timescale 1ns/1ps
module tb_lead_trail_counter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid_in = 1'b0;
  logic [4:0]  opcode = '0;
  logic [63:0] operand = '0;
  logic        valid_out;
  logic [63:0] result;
  logic        illegal_op;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  lead_trail_counter dut (
    .clk(clk), .rst(rst), .valid_in(valid_in), .opcode(opcode),
    .operand(operand), .valid_out(valid_out), .result(result),
    .illegal_op(illegal_op)
  );

  typedef struct packed {
    logic [4:0]  opc;
    logic [63:0] src;
    logic [6:0]  exp;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t TABLE [14] = '{
    '{5'd9,  64'h0000_0000_0000_0001, 7'd63, 4'd2},  // R2
    '{5'd9,  64'h8000_0000_0000_0000, 7'd0,  4'd2},  // R2
    '{5'd9,  64'h0000_0000_0000_0000, 7'd64, 4'd7},  // R7
    '{5'd8,  64'hFFFF_0000_0000_0000, 7'd16, 4'd3},  // R3
    '{5'd8,  64'hFFFF_FFFF_FFFF_FFFF, 7'd64, 4'd7},  // R7
    '{5'd11, 64'h0000_0000_0001_0000, 7'd16, 4'd4},  // R4
    '{5'd10, 64'h0000_0000_0000_00FF, 7'd8,  4'd4},  // R4
    '{5'd5,  64'hFFFF_FFFF_0000_1000, 7'd19, 4'd5},  // R5
    '{5'd5,  64'hFFFF_FFFF_0000_0000, 7'd32, 4'd6},  // R6
    '{5'd7,  64'hFFFF_FFFF_0000_0000, 7'd32, 4'd6},  // R6
    '{5'd4,  64'h0000_0000_F000_0000, 7'd4,  4'd3},  // R3
    '{5'd6,  64'hFFFF_FFFF_FFFF_FFFF, 7'd32, 4'd6},  // R6
    '{5'd11, 64'h8000_0000_0000_0000, 7'd63, 4'd4},  // R4
    '{5'd6,  64'h0000_0000_0000_0007, 7'd3,  4'd1}   // R1
  };

  function automatic logic [63:0] ref_count(logic [4:0] c, logic [63:0] s);
    logic [2:0] k;
    logic [63:0] v;
    int n, cnt, idx;
    bit stop;
    if (c < 5'd4 || c > 5'd11) return 64'd0;
    k = 3'(c - 5'd4);
    n = k[2] ? 64 : 32;
    v = k[0] ? s : ~s;
    cnt = 0;
    stop = 1'b0;
    for (int i = 0; i < n; i++) begin
      idx = k[1] ? i : n - 1 - i;
      if (!stop) begin
        if (v[idx]) stop = 1'b1;
        else cnt++;
      end
    end
    return 64'(cnt);
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(logic [4:0] c, logic [63:0] s);
    @(negedge clk);
    valid_in = 1'b1;
    opcode   = c;
    operand  = s;
    @(negedge clk);
    valid_in = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    // R11: reset state
    repeat (3) @(negedge clk);
    chk("R11 valid_out in reset", 64'(valid_out), 64'd0);
    chk("R11 result in reset", result, 64'd0);
    chk("R11 illegal_op in reset", 64'(illegal_op), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 valid_out after reset", 64'(valid_out), 64'd0);
    chk("R11 result after reset", result, 64'd0);

    // Table of directed vectors
    foreach (TABLE[i]) begin
      issue(TABLE[i].opc, TABLE[i].src);
      chk($sformatf("R%0d table[%0d] result", TABLE[i].req, i), result, 64'(TABLE[i].exp));
      chk($sformatf("R9 table[%0d] valid_out", i), 64'(valid_out), 64'd1);
      chk($sformatf("R10 table[%0d] legal flag", i), 64'(illegal_op), 64'd0);
    end

    // R9: strobe drops one cycle after a single request
    @(negedge clk);
    chk("R9 valid_out low after gap", 64'(valid_out), 64'd0);

    // R5: upper word varied, low word fixed
    issue(5'd5, 64'h0000_0000_0000_1000);
    chk("R5 upper zero", result, 64'd19);
    issue(5'd5, 64'hA5A5_5A5A_0000_1000);
    chk("R5 upper pattern", result, 64'd19);
    issue(5'd7, 64'h1234_5678_0000_0000);
    chk("R6 trailing upper nonzero", result, 64'd32);

    // R10: illegal opcodes
    issue(5'd3, 64'h0000_0000_0000_0001);
    chk("R10 code 3 result", result, 64'd0);
    chk("R10 code 3 flag", 64'(illegal_op), 64'd1);
    issue(5'd12, 64'd0);
    chk("R10 code 12 result", result, 64'd0);
    chk("R10 code 12 flag", 64'(illegal_op), 64'd1);
    issue(5'd31, 64'd0);
    chk("R10 code 31 flag", 64'(illegal_op), 64'd1);
    issue(5'd0, 64'd0);
    chk("R10 code 0 flag", 64'(illegal_op), 64'd1);

    // R12: hold while idle
    issue(5'd9, 64'h0000_0000_0000_0001);
    chk("R12 setup result", result, 64'd63);
    @(negedge clk);
    opcode  = 5'd3;
    operand = 64'd0;
    @(negedge clk);
    @(negedge clk);
    chk("R12 result held", result, 64'd63);
    chk("R12 flag held", 64'(illegal_op), 64'd0);
    chk("R12 valid_out idle", 64'(valid_out), 64'd0);

    // R1 R8: randomized operands against the loop-based reference
    for (int n = 0; n < 400; n++) begin
      logic [4:0]  c;
      logic [63:0] s;
      c = 5'(4 + ($urandom % 8));
      s = {$urandom, $urandom};
      case ($urandom % 4)
        0: s = s >> ($urandom % 65);
        1: s = s << ($urandom % 65);
        2: s = ~(s >> ($urandom % 65));
        default: ;
      endcase
      issue(c, s);
      chk($sformatf("R1 random op %0d src %0h", c, s), result, ref_count(c, s));
    end

    finish_run();
  end
endmodule